// File: doc/BRIEF.md
# T1 Transmit Channel Overlay

This block sits in the transmit path of a 24-channel T1 framer, just ahead of the serializer. For every outgoing DS0 byte it can replace the byte with a programmable idle pattern. It inserts robbed-bit signaling into the least significant bit in the two signaling frames of the 12-frame superframe. It forces bit 7 to one when a byte would go out as all zeros. It clears bit 2 of every channel while a D4 yellow alarm is being transmitted. Two per-channel masks select the channels that are idled and the channels that are left clear. A clear channel gets neither signaling nor zero-code stuffing.

A host programs the masks and the idle pattern through a byte-wide register port. The framer supplies one byte per cycle together with its channel index, its frame number and that channel's A and B signaling bits. The line-level controls arrive as static inputs: D4 mode, yellow transmit, and a pair of flags that together force stuffing on every channel. Each edited byte comes out one clock later with its valid flag.

Bits are numbered 1 (most significant, data bit 7) to 8 (least significant, data bit 0) throughout.

Top module: `t1_tx_overlay`

## Requirements
- R1: After an active-low reset, every mask register and the idle pattern read back 0 and `out_valid` is 0. With these reset values the channels pass through as non-transparent and non-idle.
- R2: The clear-channel mask is at addresses 0x39, 0x3A and 0x3B, and the idle-select mask is at 0x3C, 0x3D and 0x3E. Channel n (1..24, carried as `in_chan` = n-1) uses bit (n-1) mod 8 of register base + (n-1) div 8. The idle pattern is at 0x3F. All seven read back what was written.
- R3: `out_valid` equals `in_valid` of the previous cycle, and `out_byte` carries the edit of the byte accepted in that cycle.
- R4: A channel whose idle bit is 1 has its byte replaced by the idle pattern before any other edit. This applies to clear channels as well.
- R5: For a non-clear channel, bit 8 is replaced by `in_sig_a` when `in_frame` is 6 and by `in_sig_b` when `in_frame` is 12. In every other frame bit 8 is left unchanged.
- R6: For a non-clear channel, a byte that is 0x00 after signaling insertion leaves as 0x02, because bit 7 is set.
- R7: A clear channel (mask bit 1) receives no signaling and no stuffing. When the force flags are not both set and yellow is not active, its byte, or the idle pattern if idled, passes unchanged.
- R8: When `stuff_all_a` and `stuff_all_b` are both 1, stuffing applies to every channel, clear ones included, while clear channels still skip signaling.
- R9: While `d4_mode` and `yellow_tx` are both 1, bit 2 (mask 0x40) of every channel is cleared as the final edit, including clear and idled channels.
- R10: Writes to addresses outside 0x39..0x3F change no register, and reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 8 | Register byte address |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| d4_mode | input | 1 | D4 superframe framing selected |
| yellow_tx | input | 1 | Yellow alarm being transmitted |
| stuff_all_a | input | 1 | First of two flags forcing stuffing on all channels |
| stuff_all_b | input | 1 | Second of two flags forcing stuffing on all channels |
| in_valid | input | 1 | Input byte valid |
| in_chan | input | 5 | Channel index 0..23 (channel 1..24) |
| in_frame | input | 4 | Frame number 1..12 within the superframe |
| in_sig_a | input | 1 | Channel A signaling bit |
| in_sig_b | input | 1 | Channel B signaling bit |
| in_byte | input | 8 | DS0 byte before editing |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Edited DS0 byte |

## Verification
The datapath is swept over all 24 channels under three mask and idle-pattern settings. These settings give every mix of clear and idle bits, including an all-zero idle pattern and an idle pattern of 0x40. Frames 1, 7, 6 and 12 separate the unsignaled frames from the A and B frames, and opposite A/B values show which of the two was inserted. The bytes 0x00, 0x01, 0x02, 0x40 and 0xA5 show whether stuffing fires only on a true zero after signaling, and whether the yellow edit comes last. All sixteen combinations of the two force flags, D4 mode and yellow are applied to each vector, so a single-flag force can be told apart from the two-flag force. Register checks cover the reset values, readback and writes to unmapped addresses.

// File: rtl/t1_ovl_pkg.sv
// Shared constants and types for the T1 transmit overlay.
// Assumes bit 1 of a DS0 byte is its MSB (data bit 7) and bit 8 its LSB.
package t1_ovl_pkg;
    localparam int BYTE_W   = 8;
    localparam int BIT8_POS = 0;   // signaling bit position
    localparam int BIT7_POS = 1;   // zero-code stuffing position
    localparam int BIT2_POS = 6;   // yellow alarm position

    typedef struct packed {
        logic d4;
        logic yellow;
        logic stuff_all;
    } line_ctl_t;
endpackage

// File: rtl/t1_ovl_regs.sv
// Host register file: clear-channel mask, idle-select mask and idle pattern.
// Assumes NUM_CH is a multiple of 8; one byte register per group of 8 channels.
module t1_ovl_regs #(
    parameter int NUM_CH    = 24,
    parameter int ADDR_W    = 8,
    parameter int TR_BASE   = 'h39,
    parameter int ID_BASE   = 'h3C,
    parameter int IDLE_ADDR = 'h3F
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [t1_ovl_pkg::BYTE_W-1:0] wdata,
    output logic [t1_ovl_pkg::BYTE_W-1:0] rdata,
    output logic [NUM_CH-1:0]           transp_mask,
    output logic [NUM_CH-1:0]           idle_mask,
    output logic [t1_ovl_pkg::BYTE_W-1:0] idle_code
);
    import t1_ovl_pkg::*;
    localparam int NUM_GRP = NUM_CH / BYTE_W;

    logic [BYTE_W-1:0] tr_q [NUM_GRP];
    logic [BYTE_W-1:0] id_q [NUM_GRP];

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        // Write one group byte of each mask when its address is strobed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tr_q[g] <= '0;
                id_q[g] <= '0;
            end else if (we) begin
                if (addr == ADDR_W'(TR_BASE + g)) tr_q[g] <= wdata;
                if (addr == ADDR_W'(ID_BASE + g)) id_q[g] <= wdata;
            end
        end
        assign transp_mask[g*BYTE_W +: BYTE_W] = tr_q[g];
        assign idle_mask[g*BYTE_W +: BYTE_W]   = id_q[g];
    end

    // Write the idle pattern register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    idle_code <= '0;
        else if (we && addr == ADDR_W'(IDLE_ADDR))     idle_code <= wdata;
    end

    // Select read data; unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (addr == ADDR_W'(TR_BASE + g)) rdata = tr_q[g];
            if (addr == ADDR_W'(ID_BASE + g)) rdata = id_q[g];
        end
        if (addr == ADDR_W'(IDLE_ADDR)) rdata = idle_code;
    end
endmodule

// File: rtl/t1_ovl_edit.sv
// Combinational edit of one DS0 byte: idle substitution, robbed-bit
// signaling, bit 7 stuffing and yellow bit-2 clearing, in that order.
// Assumes the frame number counts 1..SF_LEN within the superframe.
module t1_ovl_edit #(
    parameter int FRAME_W = 4,
    parameter int SIG_FA  = 6,
    parameter int SIG_FB  = 12
) (
    input  logic [t1_ovl_pkg::BYTE_W-1:0] byte_in,
    input  logic [t1_ovl_pkg::BYTE_W-1:0] idle_code,
    input  logic                          transp,
    input  logic                          idle,
    input  logic [FRAME_W-1:0]            frame,
    input  logic                          sig_a,
    input  logic                          sig_b,
    input  t1_ovl_pkg::line_ctl_t         ctl,
    output logic [t1_ovl_pkg::BYTE_W-1:0] byte_out
);
    import t1_ovl_pkg::*;

    // Apply the four edits in order on a working copy.
    always_comb begin
        byte_out = idle ? idle_code : byte_in;
        if (!transp) begin
            if (frame == FRAME_W'(SIG_FA))      byte_out[BIT8_POS] = sig_a;
            else if (frame == FRAME_W'(SIG_FB)) byte_out[BIT8_POS] = sig_b;
        end
        if ((!transp || ctl.stuff_all) && byte_out == '0)
            byte_out[BIT7_POS] = 1'b1;
        if (ctl.d4 && ctl.yellow)
            byte_out[BIT2_POS] = 1'b0;
    end
endmodule

// File: rtl/t1_tx_overlay.sv
// T1 transmit per-channel overlay. Looks up the channel's clear and idle
// bits, edits the byte and registers it with its valid flag (one cycle).
// Assumes in_chan < NUM_CH; larger indices are edited as plain channels.
module t1_tx_overlay #(
    parameter int NUM_CH  = 24,
    parameter int CH_W    = $clog2(NUM_CH),
    parameter int FRAME_W = 4,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              d4_mode,
    input  logic              yellow_tx,
    input  logic              stuff_all_a,
    input  logic              stuff_all_b,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [FRAME_W-1:0] in_frame,
    input  logic              in_sig_a,
    input  logic              in_sig_b,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    output logic [7:0]        out_byte
);
    import t1_ovl_pkg::*;

    logic [NUM_CH-1:0] transp_mask;
    logic [NUM_CH-1:0] idle_mask;
    logic [BYTE_W-1:0] idle_code;
    logic              ch_ok, ch_tr, ch_id;
    line_ctl_t         ctl;
    logic [BYTE_W-1:0] edited;

    t1_ovl_regs #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
        .TR_BASE('h39), .ID_BASE('h3C), .IDLE_ADDR('h3F)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr),
        .wdata(host_wdata), .rdata(host_rdata),
        .transp_mask(transp_mask), .idle_mask(idle_mask), .idle_code(idle_code)
    );

    // Look up this channel's mask bits and gather line controls.
    always_comb begin
        ch_ok         = (int'(in_chan) < NUM_CH);
        ch_tr         = ch_ok ? transp_mask[in_chan] : 1'b0;
        ch_id         = ch_ok ? idle_mask[in_chan]   : 1'b0;
        ctl.d4        = d4_mode;
        ctl.yellow    = yellow_tx;
        ctl.stuff_all = stuff_all_a & stuff_all_b;
    end

    t1_ovl_edit #(.FRAME_W(FRAME_W), .SIG_FA(6), .SIG_FB(12)) u_edit (
        .byte_in(in_byte), .idle_code(idle_code), .transp(ch_tr), .idle(ch_id),
        .frame(in_frame), .sig_a(in_sig_a), .sig_b(in_sig_b), .ctl(ctl),
        .byte_out(edited)
    );

    // Register the edited byte and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_byte <= edited;
        end
    end
endmodule

// File: rtl/t1_tx_overlay_chk.sv
// Property checker for t1_tx_overlay, attached with bind. Relates the
// register file's mask outputs and the ports across the one-cycle pipeline.
module t1_tx_overlay_chk #(
    parameter int NUM_CH = 24,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [CH_W-1:0]   in_chan,
    input logic [7:0]        in_byte,
    input logic              d4_mode,
    input logic              yellow_tx,
    input logic              stuff_all_a,
    input logic              stuff_all_b,
    input logic              out_valid,
    input logic [7:0]        out_byte,
    input logic [NUM_CH-1:0] transp_mask,
    input logic [NUM_CH-1:0] idle_mask,
    input logic [7:0]        idle_code
);
    logic c_tr, c_id, c_yel, c_all;

    // Channel mask bits and line state seen by the checker.
    always_comb begin
        c_tr  = (int'(in_chan) < NUM_CH) ? transp_mask[in_chan] : 1'b0;
        c_id  = (int'(in_chan) < NUM_CH) ? idle_mask[in_chan]   : 1'b0;
        c_yel = d4_mode & yellow_tx;
        c_all = stuff_all_a & stuff_all_b;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R3
    AST_IDLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R3
    AST_IDLE_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_id && c_tr && !c_all && !c_yel) |=> out_byte == $past(idle_code));  // R4
    AST_NO_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!c_tr || c_all) && !c_yel) |=> out_byte != 8'h00);  // R6
    AST_CLEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_tr && !c_id && !c_all && !c_yel) |=> out_byte == $past(in_byte));  // R7
    AST_YELLOW_BIT2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_yel) |=> !out_byte[6]);  // R9
endmodule

bind t1_tx_overlay t1_tx_overlay_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_byte(in_byte), .d4_mode(d4_mode), .yellow_tx(yellow_tx),
    .stuff_all_a(stuff_all_a), .stuff_all_b(stuff_all_b),
    .out_valid(out_valid), .out_byte(out_byte),
    .transp_mask(transp_mask), .idle_mask(idle_mask), .idle_code(idle_code)
);

// File: tb/t1_tx_overlay_test.sv
`timescale 1ns/1ps
module t1_tx_overlay_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;
    logic       d4_mode = 0, yellow_tx = 0, stuff_all_a = 0, stuff_all_b = 0;
    logic       in_valid = 0, in_sig_a = 0, in_sig_b = 0;
    logic [4:0] in_chan = '0;
    logic [3:0] in_frame = 4'd1;
    logic [7:0] in_byte = '0;
    logic       out_valid;
    logic [7:0] out_byte;

    int n_chk = 0, n_fail = 0;
    logic [23:0] tm, im;
    logic [7:0]  ic;

    always #4 clk = ~clk;

    t1_tx_overlay uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .d4_mode(d4_mode),
        .yellow_tx(yellow_tx), .stuff_all_a(stuff_all_a), .stuff_all_b(stuff_all_b),
        .in_valid(in_valid), .in_chan(in_chan), .in_frame(in_frame),
        .in_sig_a(in_sig_a), .in_sig_b(in_sig_b), .in_byte(in_byte),
        .out_valid(out_valid), .out_byte(out_byte)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        host_addr = a;
        #1 chk(tag, host_rdata, exp);
    endtask

    // Program masks and idle pattern: group k of a mask at base + k.
    task automatic setup(input logic [23:0] t, input logic [23:0] i, input logic [7:0] c);
        tm = t; im = i; ic = c;
        for (int k = 0; k < 3; k++) begin
            wr(8'h39 + 8'(k), t[8*k +: 8]);
            wr(8'h3C + 8'(k), i[8*k +: 8]);
        end
        wr(8'h3F, c);
    endtask

    function automatic logic [7:0] model(input int ch, input int fr, input logic [7:0] b,
                                         input logic a, input logic bb, input logic d4,
                                         input logic yl, input logic fa, input logic fb);
        logic [7:0] v;
        v = im[ch] ? ic : b;
        if (!tm[ch] && fr == 6)  v = {v[7:1], a};
        if (!tm[ch] && fr == 12) v = {v[7:1], bb};
        if ((!tm[ch] || (fa && fb)) && v == 8'h00) v = 8'h02;
        if (d4 && yl) v = v & 8'hBF;
        return v;
    endfunction

    function automatic string tag_of(input int ch, input int fr, input logic [7:0] b,
                                     input logic d4, input logic yl, input logic fa, input logic fb);
        if (d4 && yl)             return "R9 yellow";
        if (im[ch])               return "R4 idle";
        if (tm[ch] && fa && fb)   return "R8 forced stuffing";
        if (tm[ch])               return "R7 clear channel";
        if (fr == 6 || fr == 12)  return "R5 signaling";
        if (b == 8'h00)           return "R6 stuffing";
        return "R3 pass";
    endfunction

    function automatic logic [7:0] pat(input int k);
        case (k)
            0: return 8'h00;
            1: return 8'h01;
            2: return 8'h02;
            3: return 8'h40;
            default: return 8'hA5;
        endcase
    endfunction

    function automatic int frm(input int k);
        case (k)
            0: return 1;
            1: return 6;
            2: return 12;
            default: return 7;
        endcase
    endfunction

    // Full sweep of channels, frames, bytes, signaling and line controls.
    task automatic sweep();
        for (int ch = 0; ch < 24; ch++)
        for (int f = 0; f < 4; f++)
        for (int p = 0; p < 5; p++)
        for (int s = 0; s < 2; s++)
        for (int m = 0; m < 16; m++) begin
            logic [7:0] e;
            @(negedge clk);
            in_valid = 1; in_chan = 5'(ch); in_frame = 4'(frm(f)); in_byte = pat(p);
            in_sig_a = (s == 0); in_sig_b = (s == 1);
            d4_mode = m[0]; yellow_tx = m[1]; stuff_all_a = m[2]; stuff_all_b = m[3];
            e = model(ch, frm(f), pat(p), in_sig_a, in_sig_b, m[0], m[1], m[2], m[3]);
            @(posedge clk);
            #2 chk(tag_of(ch, frm(f), pat(p), m[0], m[1], m[2], m[3]), out_byte, e);
        end
        @(negedge clk);
        in_valid = 0; d4_mode = 0; yellow_tx = 0; stuff_all_a = 0; stuff_all_b = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        #1 chk("R1 out_valid after reset", {7'd0, out_valid}, 8'h00);
        for (int a = 8'h39; a <= 8'h3F; a++) rd_chk("R1 register reset", 8'(a), 8'h00);

        // R3: valid low produces no output; valid high appears one cycle later
        @(negedge clk); in_valid = 0;
        @(posedge clk); #2 chk("R3 no valid", {7'd0, out_valid}, 8'h00);
        @(negedge clk); in_valid = 1; in_chan = 0; in_frame = 1; in_byte = 8'h5A;
        #1 chk("R3 not yet valid", {7'd0, out_valid}, 8'h00);
        @(posedge clk); #2 chk("R3 valid after one cycle", {7'd0, out_valid}, 8'h01);
        chk("R3 byte after one cycle", out_byte, 8'h5A);
        @(negedge clk); in_valid = 0;

        // R2: register map readback
        setup(24'h5AC30F, 24'h0F3381, 8'h00);
        for (int k = 0; k < 3; k++) begin
            rd_chk("R2 clear mask readback", 8'h39 + 8'(k), tm[8*k +: 8]);
            rd_chk("R2 idle mask readback", 8'h3C + 8'(k), im[8*k +: 8]);
        end
        rd_chk("R2 idle pattern readback", 8'h3F, 8'h00);

        // R10: unmapped writes are ignored, unmapped reads give zero
        wr(8'h38, 8'hFF);
        wr(8'h40, 8'hFF);
        wr(8'h00, 8'hFF);
        rd_chk("R10 unmapped read", 8'h38, 8'h00);
        rd_chk("R10 unmapped read", 8'h40, 8'h00);
        for (int k = 0; k < 3; k++) begin
            rd_chk("R10 clear mask kept", 8'h39 + 8'(k), tm[8*k +: 8]);
            rd_chk("R10 idle mask kept", 8'h3C + 8'(k), im[8*k +: 8]);
        end
        rd_chk("R10 idle pattern kept", 8'h3F, 8'h00);

        // Datapath sweeps over three configurations
        setup(24'h000000, 24'h000000, 8'h00);
        sweep();
        setup(24'h5AC30F, 24'h0F3381, 8'h00);
        sweep();
        setup(24'hFF00F0, 24'h8118CC, 8'h40);
        sweep();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule